// File: doc/BRIEF.md
# UART Transmit Steering Front End with Half-Duplex Direction Control

This block sits between the host write port of a UART and its transmit shift register. Each host byte either joins a 16-entry transmit queue or, when a one-shot "send now" control is armed, goes to a one-byte holding register that is served ahead of everything queued. The same holding register is the only transmit buffer when the queue is switched off. The shift register is modelled outside the block as a unit that accepts a byte on a load strobe, reports busy, and pulses done when the stop bit of that byte completes.

The "send now" control arms on a host pulse and disarms by itself once the single byte it let through has finished on the line, so software re-arms it for every urgent byte. The block also drives an active-low request-to-send pin that marks the transmit direction for a half-duplex RS485 driver. A polarity control selects which level means "transmitting".

Top module: `uart_tx_steer`

## Requirements
- R1: After reset the send-now flag `now_flag` reads 0, `rts_n` is high (with `rts_pol` = 0) and `sh_load` is low.
- R2: With the queue on (`q_en` = 1) and `now_flag` = 0, written bytes leave on `sh_data` in the order they were written, one load per byte.
- R3: With the queue on and `now_flag` = 1, the next written byte bypasses the queue: it is loaded into the shift register before any byte that was already queued, as soon as the shift register is free.
- R4: Only one byte bypasses per arming: further writes while `now_flag` is still 1 join the queue behind the bytes already there.
- R5: `now_flag` stays 1 until the `sh_done` pulse of the bypassed byte and reads 0 after it; a byte written after that is queued normally.
- R6: With `rts_pol` = 0, `rts_n` is 0 from the cycle after the first load until the transmission ends, and 1 when idle.
- R7: With `rts_pol` = 1, `rts_n` is 1 while transmitting and 0 when idle.
- R8: The transmit state lasts across back-to-back bytes and ends only on an `sh_done` pulse when the queue and the holding register are both empty.
- R9: With the queue off (`q_en` = 0), `now_flag` has no effect and is not cleared; writes go through the holding register, and a write arriving while the holding register is full and not being emptied that cycle is dropped.
- R10: `sh_load` is never asserted while `sh_busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Host byte |
| q_en | input | 1 | Transmit queue enable |
| now_arm | input | 1 | One-cycle pulse that arms the send-now flag |
| rts_pol | input | 1 | 0: `rts_n` low while transmitting; 1: high while transmitting |
| sh_busy | input | 1 | Shift register is sending a byte (rises the cycle after a load) |
| sh_done | input | 1 | One-cycle pulse: stop bit of the current byte complete |
| sh_load | output | 1 | Load strobe to the shift register |
| sh_data | output | 8 | Byte presented with `sh_load` |
| now_flag | output | 1 | Current state of the send-now flag |
| rts_n | output | 1 | Active-low direction pin for the RS485 driver |

## Verification
The bench aims at the ordering corner: a bypass byte written while the shift register is busy and several bytes are queued must come out second, and a byte written right after it must come out last; a design that routed the bypass into the queue, or let two bytes through, would show a shifted order. It watches `now_flag` across the bypassed byte's flight, because clearing on load rather than on done, or never clearing, shows up there. It sweeps burst lengths under both direction polarities so that a direction pin that toggles between back-to-back bytes or has inverted polarity is caught, and it checks that with the queue off a third write into a full holding register is dropped while the flag survives.

// File: rtl/uart_tx_steer_pkg.sv
// Shared types for the transmit steering front end.
// Assumes: byte-wide host data.
package uart_tx_steer_pkg;
    localparam int BYTE_W = 8;

    // Destination of a host write in the current cycle.
    typedef enum logic [1:0] {
        DST_DROP = 2'd0,
        DST_QUEUE = 2'd1,
        DST_HOLD = 2'd2
    } dst_t;
endpackage

// File: rtl/uart_tx_queue.sv
// Synchronous FIFO for queued transmit bytes.
// Assumes: caller never pushes when full nor pops when empty; DEPTH is a power of two.
module uart_tx_queue #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wp;
    logic [AW:0]      rp;

    assign empty = (wp == rp);
    assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign head  = mem[rp[AW-1:0]];

    // Pointer update on push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (push) mem[wp[AW-1:0]] <= push_data;
    end

    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/uart_tx_hold.sv
// One-entry holding register with a tag bit marking a bypass byte.
// Assumes: push only when empty or popped in the same cycle.
module uart_tx_hold #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             push_tag,
    input  logic             pop,
    output logic             valid,
    output logic [WIDTH-1:0] data,
    output logic             tag
);
    // Occupancy, contents and tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            data  <= '0;
            tag   <= 1'b0;
        end else if (push) begin
            valid <= 1'b1;
            data  <= push_data;
            tag   <= push_tag;
        end else if (pop) begin
            valid <= 1'b0;
            tag   <= 1'b0;
        end
    end

    a_r9_hold_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        (push && valid) |-> pop);
endmodule

// File: rtl/uart_tx_dir.sv
// Transmit-direction tracker driving the active-low RS485 request-to-send pin.
// Assumes: done pulses once per byte at its stop-bit end.
module uart_tx_dir (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic done,
    input  logic drained,
    input  logic pol,
    output logic active,
    output logic rts_n
);
    // Enter transmit on a load; leave on done when nothing is left.
    always_ff @(posedge clk) begin
        if (!rst_n)                active <= 1'b0;
        else if (load)             active <= 1'b1;
        else if (done && drained)  active <= 1'b0;
    end

    // pol=0: low while sending; pol=1: high while sending.
    assign rts_n = ~(active ^ pol);

    a_r8_end_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(active) |-> $past(done && drained));
    a_r6_active_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> active);
endmodule

// File: rtl/uart_tx_steer.sv
// Transmit steering front end: routes host bytes to a queue or a one-byte
// bypass/holding register, feeds the shift register, tracks the send-now flag.
// Assumes: sh_busy rises the cycle after sh_load; sh_done pulses with sh_busy low.
module uart_tx_steer
    import uart_tx_steer_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              q_en,
    input  logic              now_arm,
    input  logic              rts_pol,
    input  logic              sh_busy,
    input  logic              sh_done,
    output logic              sh_load,
    output logic [BYTE_W-1:0] sh_data,
    output logic              now_flag,
    output logic              rts_n
);
    logic              q_push, q_pop, q_empty, q_full;
    logic [BYTE_W-1:0] q_head;
    logic              h_push, h_pop, h_valid, h_tag, h_free;
    logic [BYTE_W-1:0] h_data;
    logic              byp_taken, byp_flying, tx_active;
    logic              byp_ok;
    dst_t              dst;

    // Shift register service: holding register first, then queue.
    assign sh_load = !sh_busy && (h_valid || !q_empty);
    assign h_pop   = sh_load && h_valid;
    assign q_pop   = sh_load && !h_valid;
    assign sh_data = h_valid ? h_data : q_head;
    assign h_free  = !h_valid || h_pop;
    assign byp_ok  = q_en && now_flag && !byp_taken && h_free;

    // Destination of the current write.
    always_comb begin
        dst = DST_DROP;
        if (wr_en) begin
            if (!q_en)       dst = h_free ? DST_HOLD : DST_DROP;
            else if (byp_ok) dst = DST_HOLD;
            else             dst = q_full ? DST_DROP : DST_QUEUE;
        end
    end

    assign q_push = (dst == DST_QUEUE);
    assign h_push = (dst == DST_HOLD);

    uart_tx_queue #(.WIDTH(BYTE_W), .DEPTH(DEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push(q_push), .push_data(wr_data),
        .pop(q_pop), .head(q_head),
        .empty(q_empty), .full(q_full)
    );

    uart_tx_hold #(.WIDTH(BYTE_W)) u_hold (
        .clk(clk), .rst_n(rst_n),
        .push(h_push), .push_data(wr_data), .push_tag(byp_ok),
        .pop(h_pop), .valid(h_valid), .data(h_data), .tag(h_tag)
    );

    // Send-now flag: armed by host, cleared when the bypassed byte completes.
    always_ff @(posedge clk) begin
        if (!rst_n)                       now_flag <= 1'b0;
        else if (now_arm)                 now_flag <= 1'b1;
        else if (sh_done && byp_flying)   now_flag <= 1'b0;
    end

    // Bypass bookkeeping: one byte taken per arming; track it on the line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byp_taken  <= 1'b0;
            byp_flying <= 1'b0;
        end else begin
            if (sh_done && byp_flying) begin
                byp_taken  <= 1'b0;
                byp_flying <= 1'b0;
            end
            if (h_push && byp_ok)  byp_taken  <= 1'b1;
            if (h_pop && h_tag)    byp_flying <= 1'b1;
        end
    end

    uart_tx_dir u_dir (
        .clk(clk), .rst_n(rst_n),
        .load(sh_load), .done(sh_done),
        .drained(!h_valid && q_empty),
        .pol(rts_pol), .active(tx_active), .rts_n(rts_n)
    );

    a_r10_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
        sh_load |-> !sh_busy);
    a_r5_flag_clears_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(now_flag) |-> $past(sh_done));
    a_r4_single_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (h_push && byp_taken) |-> !q_en);
    a_r3_bypass_first: assert property (@(posedge clk) disable iff (!rst_n)
        (h_valid && h_tag && !sh_busy) |-> (sh_load && sh_data == h_data));
    a_r9_flag_kept_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!q_en && !byp_flying && now_flag) |=> now_flag);
endmodule

// File: tb/uart_tx_steer_tb.sv
`timescale 1ns/1ps
module uart_tx_steer_tb;
    localparam int LEN = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       q_en = 1'b1;
    logic       now_arm = 1'b0;
    logic       rts_pol = 1'b0;
    logic       sh_busy = 1'b0;
    logic       sh_done = 1'b0;
    logic       sh_load;
    logic [7:0] sh_data;
    logic       now_flag;
    logic       rts_n;

    int errors = 0;
    int checks = 0;
    int cnt = 0;
    int nlog = 0;
    logic [7:0] log_q [64];
    logic [7:0] watch = 8'hFF;
    logic       flag_at_watch = 1'b0;

    always #2 clk = ~clk;

    uart_tx_steer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .q_en(q_en), .now_arm(now_arm), .rts_pol(rts_pol),
        .sh_busy(sh_busy), .sh_done(sh_done), .sh_load(sh_load),
        .sh_data(sh_data), .now_flag(now_flag), .rts_n(rts_n)
    );

    // Shift register model: busy for LEN cycles, done pulse at the end.
    always @(posedge clk) begin
        sh_done <= 1'b0;
        if (sh_load) begin
            if (nlog < 64) log_q[nlog] = sh_data;
            if (sh_data == watch) flag_at_watch = now_flag;
            nlog = nlog + 1;
            sh_busy <= 1'b1;
            cnt <= LEN;
        end else if (sh_busy) begin
            if (cnt == 1) begin
                sh_busy <= 1'b0;
                sh_done <= 1'b1;
            end
            cnt <= cnt - 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic arm();
        now_arm = 1'b1;
        @(negedge clk);
        now_arm = 1'b0;
    endtask

    task automatic drain(input int n);
        repeat (n * (LEN + 3) + 8) @(negedge clk);
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 now_flag", now_flag, 0);
        check("R1 rts_n", rts_n, 1);
        check("R1 sh_load", sh_load, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2/R6/R7/R8: sweep burst length and polarity
        for (int p = 0; p < 2; p++) begin
            rts_pol = p[0];
            @(negedge clk);
            check(p ? "R7 idle level" : "R6 idle level", rts_n, p ? 0 : 1);
            for (int n = 1; n <= 5; n++) begin
                nlog = 0;
                for (int i = 0; i < n; i++) wr(8'((n << 4) + i + p * 8));
                @(negedge clk);
                check(p ? "R7 tx level" : "R6 tx level", rts_n, p);
                repeat ((n - 1) * (LEN + 1) + 2) @(negedge clk);
                check("R8 held across bytes", rts_n, p);
                drain(1);
                check(p ? "R7 idle after" : "R6 idle after", rts_n, p ? 0 : 1);
                check("R10 load count", nlog, n);
                for (int i = 0; i < n; i++)
                    check("R2 order", log_q[i], (n << 4) + i + p * 8);
            end
        end
        rts_pol = 1'b0;

        // R3/R4/R5: bypass while busy with queued bytes
        nlog = 0;
        watch = 8'hA5;
        wr(8'h01); wr(8'h02); wr(8'h03); wr(8'h04);
        arm();
        check("R5 flag armed", now_flag, 1);
        wr(8'hA5);
        wr(8'h06);
        check("R5 flag held before load", now_flag, 1);
        drain(6);
        check("R10 load count bypass", nlog, 6);
        check("R3 first", log_q[0], 8'h01);
        check("R3 bypass second", log_q[1], 8'hA5);
        check("R3 queued", log_q[2], 8'h02);
        check("R3 queued", log_q[3], 8'h03);
        check("R3 queued", log_q[4], 8'h04);
        check("R4 later write queued", log_q[5], 8'h06);
        check("R5 flag at bypass load", flag_at_watch, 1);
        check("R5 flag cleared", now_flag, 0);

        // R5: bypass on an idle shifter, then normal write after clearing
        nlog = 0;
        arm();
        wr(8'h77);
        @(negedge clk);
        check("R5 flag while flying", now_flag, 1);
        drain(1);
        check("R5 flag cleared idle", now_flag, 0);
        wr(8'h11); wr(8'h12);
        drain(2);
        check("R5 normal count", nlog, 3);
        check("R5 normal order", log_q[1], 8'h11);
        check("R5 normal order", log_q[2], 8'h12);

        // R9: queue off, flag ignored, third write dropped
        nlog = 0;
        q_en = 1'b0;
        arm();
        wr(8'h31); wr(8'h32); wr(8'h33);
        drain(3);
        check("R9 count", nlog, 2);
        check("R9 order", log_q[0], 8'h31);
        check("R9 order", log_q[1], 8'h32);
        check("R9 flag kept", now_flag, 1);
        check("R9 idle", rts_n, 1);

        // R3/R5: re-enable queue, armed flag now bypasses and clears
        q_en = 1'b1;
        nlog = 0;
        wr(8'h41);
        drain(1);
        check("R3 bypass after enable", log_q[0], 8'h41);
        check("R5 flag cleared after enable", now_flag, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule